// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transmitter

This block is the transmit side of one asynchronous serial channel. A processor-side write port pushes 8-bit characters into a transmit buffer. A framer takes each character from the buffer and sends it on a single serial line. The frame is a low start bit, then the data bits, then an optional parity bit, then high stop bits. Control inputs set the character length, the parity mode and the stop-bit length. The framer latches these settings when it takes a character from the buffer.

A tick generator divides the clock by a 16-bit divisor to make a timing tick at sixteen times the bit rate. Every bit lasts 16 ticks. The buffer has two modes. In the deep mode it holds a queue of characters. In the single mode it holds one character, in front of the one being shifted out. `tx_ready` tells the writer whether there is room in the buffer. `tx_empty` is meant for interrupt logic and means no character is waiting. A break input holds the line low for as long as it is set.

Top module: `sertx_top`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `txd` is 1 (marking), `tx_ready` is 1, `tx_empty` is 1 and `tx_idle` is 1.
- R2: A frame starts with one start bit at 0. The data bits follow, least significant bit first. `char_len` codes 0, 1, 2 and 3 select 5, 6, 7 and 8 data bits.
- R3: `par_mode` 2'b01 adds an odd parity bit after the data bits, and 2'b10 adds an even parity bit. Codes 2'b00 and 2'b11 send no parity bit. Parity covers only the data bits that are sent.
- R4: With `stop_sel` 0 the stop period is 16 ticks. With `stop_sel` 1 it is 24 ticks for 5-bit characters and 32 ticks for every other length. `tx_idle` rises when the stop period ends, provided no character is waiting.
- R5: Each start, data and parity bit lasts exactly 16 ticks. A tick occurs every `divisor` clock cycles, and a divisor of 0 behaves as 1.
- R6: With `fifo_mode` 1 the buffer holds `FIFO_DEPTH` (16) characters, in addition to the one being sent. `tx_ready` is low while the buffer is full. A write while it is full is dropped. Characters leave in the order they were written.
- R7: With `fifo_mode` 0 the buffer holds one character. A write is accepted only if the holding slot is empty or is being emptied in the same cycle. Any other write is dropped.
- R8: While `break_en` is 1, `txd` is 0 from the next cycle on. The framer keeps its timing while the break is applied.
- R9: After the framer takes a character, which makes `tx_empty` high when nothing else is waiting, the start bit begins after a lead of 8 ticks of marking.
- R10: `tx_empty` is 1 exactly when the buffer holds no character, and `tx_ready` is then 1. `tx_idle` is 1 when the buffer is empty and the framer has no frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Push `wr_data` into the transmit buffer |
| wr_data | input | 8 | Character to send |
| fifo_mode | input | 1 | 1: deep buffer, 0: single holding slot |
| char_len | input | 2 | Data bits minus 5 |
| par_mode | input | 2 | 01 odd, 10 even, otherwise none |
| stop_sel | input | 1 | 0: one stop bit, 1: long stop period |
| break_en | input | 1 | Force the line to spacing |
| divisor | input | DIV_W (16) | Clock cycles per tick, 0 treated as 1 |
| txd | output | 1 | Serial line, registered |
| tx_ready | output | 1 | Buffer can accept a write |
| tx_empty | output | 1 | No character waiting in the buffer |
| tx_idle | output | 1 | Buffer empty and no frame in progress |

## Verification
The assertions assume that `divisor`, `fifo_mode` and the frame settings stay stable while a frame is being timed. They also assume that writes arrive only through `wr_en` in whole cycles, and that `break_en` changes only between clock edges. The stimulus meets these assumptions: it changes the settings only while the block is idle, or in the stretch before the first tick of a frame. The one exception is the buffer tests, which raise the tick rate during the lead interval, after the buffer has been filled. Every input is driven on the falling clock edge, and every output is sampled on the falling clock edge. Bit values are sampled in the middle of each bit, and interval lengths are checked against tick counts scaled by the divisor.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int CHAR_W     = 8;
  localparam int TCNT_W     = 5;
  localparam int BIT_TICKS  = 16;
  localparam int LEAD_TICKS = 8;

  localparam logic [1:0] PAR_ODD  = 2'b01;
  localparam logic [1:0] PAR_EVEN = 2'b10;

  typedef enum logic [2:0] {
    FR_IDLE, FR_LEAD, FR_START, FR_DATA, FR_PAR, FR_STOP
  } fr_state_t;

  function automatic logic [CHAR_W-1:0] len_mask(input logic [1:0] len);
    case (len)
      2'd0:    len_mask = 8'h1F;
      2'd1:    len_mask = 8'h3F;
      2'd2:    len_mask = 8'h7F;
      default: len_mask = 8'hFF;
    endcase
  endfunction

  function automatic logic par_bit(input logic [CHAR_W-1:0] d,
                                   input logic [1:0] len,
                                   input logic [1:0] mode);
    logic p;
    p = ^(d & len_mask(len));
    par_bit = (mode == PAR_ODD) ? ~p : p;
  endfunction

  function automatic logic [TCNT_W-1:0] stop_ticks(input logic sel,
                                                   input logic [1:0] len);
    if (!sel)            stop_ticks = TCNT_W'(BIT_TICKS);
    else if (len == 2'd0) stop_ticks = TCNT_W'(BIT_TICKS + BIT_TICKS / 2);
    else                 stop_ticks = TCNT_W'(2 * BIT_TICKS);
  endfunction
endpackage

// File: rtl/sertx_tick.sv
module sertx_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] limit;
  logic             wrap;

  assign limit = (divisor == '0) ? DIV_W'(1) : divisor;
  assign wrap  = (cnt >= limit - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      cnt  <= wrap ? '0 : cnt + DIV_W'(1);
      tick <= wrap;
    end
  end
endmodule

// File: rtl/sertx_buf.sv
module sertx_buf #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_mode,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic [CW-1:0] count,
  output logic          ready,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cap;
  logic          accept, take;

  assign cap    = fifo_mode ? CW'(DEPTH) : CW'(1);
  assign take   = pop && (count != '0);
  assign accept = push && ((count < cap) || take);
  assign ready  = (count < cap);
  assign empty  = (count == '0);
  assign pop_data = mem[rptr];

  always_ff @(posedge clk) begin
    if (accept) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (accept) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
      if (take)   rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
      case ({accept, take})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/sertx_framer.sv
module sertx_framer
  import sertx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              avail,
  input  logic [CHAR_W-1:0] in_data,
  input  logic [1:0]        char_len,
  input  logic [1:0]        par_mode,
  input  logic              stop_sel,
  output logic              pop,
  output logic              line,
  output logic              busy
);
  fr_state_t          st;
  logic [TCNT_W-1:0]  tcnt, lim, stop_lim;
  logic [2:0]         bitcnt, last_bit;
  logic [CHAR_W-1:0]  shreg;
  logic               pbit, has_par;

  assign pop  = (st == FR_IDLE) && avail;
  assign busy = (st != FR_IDLE);

  always_comb begin
    case (st)
      FR_LEAD: lim = TCNT_W'(LEAD_TICKS);
      FR_STOP: lim = stop_lim;
      default: lim = TCNT_W'(BIT_TICKS);
    endcase
  end

  always_comb begin
    case (st)
      FR_START: line = 1'b0;
      FR_DATA:  line = shreg[0];
      FR_PAR:   line = pbit;
      default:  line = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= FR_IDLE;
      tcnt     <= '0;
      bitcnt   <= '0;
      last_bit <= '0;
      shreg    <= '0;
      pbit     <= 1'b0;
      has_par  <= 1'b0;
      stop_lim <= TCNT_W'(BIT_TICKS);
    end else if (st == FR_IDLE) begin
      if (avail) begin
        shreg    <= in_data & len_mask(char_len);
        last_bit <= {1'b1, char_len};
        has_par  <= (par_mode == PAR_ODD) || (par_mode == PAR_EVEN);
        pbit     <= par_bit(in_data, char_len, par_mode);
        stop_lim <= stop_ticks(stop_sel, char_len);
        tcnt     <= '0;
        bitcnt   <= '0;
        st       <= FR_LEAD;
      end
    end else if (tick) begin
      if (tcnt == lim - TCNT_W'(1)) begin
        tcnt <= '0;
        case (st)
          FR_LEAD:  st <= FR_START;
          FR_START: st <= FR_DATA;
          FR_DATA: begin
            shreg <= shreg >> 1;
            if (bitcnt == last_bit) st <= has_par ? FR_PAR : FR_STOP;
            else                    bitcnt <= bitcnt + 3'd1;
          end
          FR_PAR:   st <= FR_STOP;
          default:  st <= FR_IDLE;
        endcase
      end else begin
        tcnt <= tcnt + TCNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/sertx_top.sv
module sertx_top
  import sertx_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int DIV_W      = 16,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CHAR_W-1:0] wr_data,
  input  logic              fifo_mode,
  input  logic [1:0]        char_len,
  input  logic [1:0]        par_mode,
  input  logic              stop_sel,
  input  logic              break_en,
  input  logic [DIV_W-1:0]  divisor,
  output logic              txd,
  output logic              tx_ready,
  output logic              tx_empty,
  output logic              tx_idle
);
  logic              tick, pop, line, busy;
  logic [CHAR_W-1:0] head;
  logic [CNT_W-1:0]  buf_count;

  sertx_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .divisor(divisor), .tick(tick)
  );

  sertx_buf #(.DW(CHAR_W), .DEPTH(FIFO_DEPTH)) u_buf (
    .clk(clk), .rst(rst), .fifo_mode(fifo_mode),
    .push(wr_en), .push_data(wr_data),
    .pop(pop), .pop_data(head),
    .count(buf_count), .ready(tx_ready), .empty(tx_empty)
  );

  sertx_framer u_framer (
    .clk(clk), .rst(rst), .tick(tick),
    .avail(!tx_empty), .in_data(head),
    .char_len(char_len), .par_mode(par_mode), .stop_sel(stop_sel),
    .pop(pop), .line(line), .busy(busy)
  );

  assign tx_idle = tx_empty && !busy;

  always_ff @(posedge clk) begin
    if (rst) txd <= 1'b1;
    else     txd <= break_en ? 1'b0 : line;
  end
endmodule

// File: rtl/sertx_check.sv
module sertx_check #(
  parameter int DEPTH = 16,
  parameter int DIV_W = 16,
  parameter int CW    = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             break_en,
  input logic [DIV_W-1:0] divisor,
  input logic             txd,
  input logic             tx_ready,
  input logic             tx_empty,
  input logic             tx_idle,
  input logic             tick,
  input logic             pop,
  input logic [CW-1:0]    buf_count
);
  assert_break_space_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(break_en) && !$past(rst)) |-> !txd);

  assert_idle_mark_R10: assert property (@(posedge clk) disable iff (rst)
    ($past(tx_idle) && !$past(break_en) && !$past(rst)) |-> txd);

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    buf_count <= CW'(DEPTH));

  assert_full_drop_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !tx_ready && !pop) |=> $stable(buf_count));

  assert_empty_ready_R10: assert property (@(posedge clk) disable iff (rst)
    tx_empty |-> tx_ready);

  assert_tick_div1_R5: assert property (@(posedge clk) disable iff (rst)
    (divisor <= DIV_W'(1) && $past(divisor <= DIV_W'(1)) && !$past(rst)) |-> tick);
endmodule

bind sertx_top sertx_check #(.DEPTH(FIFO_DEPTH), .DIV_W(DIV_W), .CW(CNT_W)) u_check (
  .clk(clk), .rst(rst), .wr_en(wr_en), .break_en(break_en), .divisor(divisor),
  .txd(txd), .tx_ready(tx_ready), .tx_empty(tx_empty), .tx_idle(tx_idle),
  .tick(tick), .pop(pop), .buf_count(buf_count)
);

// File: tb/test_sertx_top.sv
`timescale 1ns/1ps
module test_sertx_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic        fifo_mode = 1'b1;
  logic [1:0]  char_len = 2'd3;
  logic [1:0]  par_mode = 2'b00;
  logic        stop_sel = 1'b0;
  logic        break_en = 1'b0;
  logic [15:0] divisor = 16'd1;
  logic        txd, tx_ready, tx_empty, tx_idle;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sertx_top i_sertx_top (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .fifo_mode(fifo_mode), .char_len(char_len), .par_mode(par_mode),
    .stop_sel(stop_sel), .break_en(break_en), .divisor(divisor),
    .txd(txd), .tx_ready(tx_ready), .tx_empty(tx_empty), .tx_idle(tx_idle)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic nclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int exp_bits(input int len, input int d);
    return d & ((1 << (len + 5)) - 1);
  endfunction

  function automatic int exp_pbit(input int len, input int d, input int par);
    int m, p;
    m = exp_bits(len, d);
    p = 0;
    for (int i = 0; i < 8; i++) p ^= (m >> i) & 1;
    return (par == 1) ? (p ^ 1) : p;
  endfunction

  function automatic int stop_len(input int len, input int stp);
    if (stp == 0) return 16;
    return (len == 0) ? 24 : 32;
  endfunction

  task automatic write1(input int d);
    wr_en = 1'b1; wr_data = 8'(d);
    nclk(1);
    wr_en = 1'b0;
  endtask

  // Waits for a start edge and samples every bit in its middle.
  task automatic rx_frame(input int len, input int par, input int div,
                          output int d, output int ok_frame, output int fall_c);
    int n, st, pb, sp;
    n = len + 5;
    while (txd !== 1'b0) nclk(1);
    fall_c = cyc;
    nclk(8 * div);
    st = txd;
    d = 0;
    for (int i = 0; i < n; i++) begin
      nclk(16 * div);
      d |= int'(txd) << i;
    end
    pb = 0;
    if (par == 1 || par == 2) begin
      nclk(16 * div);
      pb = txd;
    end
    nclk(16 * div);
    sp = txd;
    ok_frame = (st == 0) && (sp == 1) &&
               ((par != 1 && par != 2) || pb == exp_pbit(len, d, par));
  endtask

  // R2 R3 R4 R5 R9: one character end to end from an idle block.
  task automatic send_check(input int d, input int len, input int par, input int stp,
                            input int dv, input string tag);
    int got, okf, fc, ec, div, ticks, span;
    div = (dv == 0) ? 1 : dv;
    char_len = 2'(len); par_mode = 2'(par); stop_sel = 1'(stp); divisor = 16'(dv);
    write1(d);
    while (tx_empty !== 1'b1) nclk(1);
    ec = cyc;
    rx_frame(len, par, div, got, okf, fc);
    chk((fc - ec) >= 7 * div && (fc - ec) <= 9 * div + 2, {"R9 lead ", tag}, fc - ec, 8 * div);
    chk(got == exp_bits(len, d), {"R2 data ", tag}, got, exp_bits(len, d));
    chk(okf == 1, {"R3 start/parity/stop ", tag}, okf, 1);
    while (tx_idle !== 1'b1) nclk(1);
    ticks = 16 * (1 + len + 5 + ((par == 1 || par == 2) ? 1 : 0)) + stop_len(len, stp);
    span  = cyc - fc;
    chk(span >= ticks * div - 3 && span <= ticks * div + 2, {"R4 R5 frame length ", tag},
        span, ticks * div - 1);
    nclk(2);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int got, okf, fc;
    nclk(1);
    // R1 during reset
    chk(txd === 1'b1, "R1 txd in reset", int'(txd), 1);
    nclk(2);
    rst = 1'b0;
    nclk(1);
    chk(txd === 1'b1, "R1 txd after reset", int'(txd), 1);
    chk(tx_ready === 1'b1, "R1 tx_ready", int'(tx_ready), 1);
    chk(tx_empty === 1'b1, "R1 R10 tx_empty", int'(tx_empty), 1);
    chk(tx_idle === 1'b1, "R1 R10 tx_idle", int'(tx_idle), 1);

    // R2 R3 R4: all lengths, parity codes (including 11) and stop settings
    for (int len = 0; len < 4; len++)
      for (int par = 0; par < 4; par++)
        for (int stp = 0; stp < 2; stp++)
          send_check((8'hA5 ^ (len * 37 + par * 11 + stp * 5)) & 255, len, par, stp, 1,
                     $sformatf("len%0d par%0d stp%0d", len, par, stp));

    // R2 R3: every 8-bit value with even parity, 5-bit values with odd parity
    for (int d = 0; d < 256; d++) send_check(d, 3, 2, 0, 1, $sformatf("d%0d", d));
    for (int d = 0; d < 32; d++)  send_check(d, 0, 1, 1, 1, $sformatf("d5_%0d", d));

    // R5: divisor 0 acts as 1, other divisors stretch every bit
    send_check(8'h3C, 3, 0, 0, 0, "div0");
    send_check(8'h96, 2, 1, 1, 2, "div2");
    send_check(8'h5A, 1, 2, 0, 5, "div5");

    // R8: break while idle and during a frame
    divisor = 16'd1;
    break_en = 1'b1; nclk(2);
    chk(txd === 1'b0, "R8 break idle", int'(txd), 0);
    break_en = 1'b0; nclk(2);
    chk(txd === 1'b1, "R8 release idle", int'(txd), 1);
    char_len = 2'd3; par_mode = 2'b00; stop_sel = 1'b0;
    write1(8'hFF);
    nclk(60);
    break_en = 1'b1; nclk(3);
    chk(txd === 1'b0, "R8 break mid-frame", int'(txd), 0);
    break_en = 1'b0;
    while (tx_idle !== 1'b1) nclk(1);
    nclk(2);
    chk(txd === 1'b1, "R8 line after frame", int'(txd), 1);
    send_check(8'h81, 3, 0, 0, 1, "after break");

    // R6: deep buffer fill, overflow drop and order
    fifo_mode = 1'b1; divisor = 16'd1000;
    char_len = 2'd3; par_mode = 2'b00; stop_sel = 1'b0;
    for (int i = 0; i < 17; i++) begin
      wr_en = 1'b1; wr_data = 8'((i * 29 + 3) & 255);
      nclk(1);
    end
    wr_en = 1'b0;
    nclk(1);
    chk(tx_ready === 1'b0, "R6 ready low when full", int'(tx_ready), 0);
    chk(tx_empty === 1'b0, "R6 R10 not empty", int'(tx_empty), 0);
    write1(8'hEE);
    divisor = 16'd1;
    for (int i = 0; i < 17; i++) begin
      rx_frame(3, 0, 1, got, okf, fc);
      chk(got == ((i * 29 + 3) & 255) && okf == 1, $sformatf("R6 order %0d", i),
          got, (i * 29 + 3) & 255);
    end
    while (tx_idle !== 1'b1) nclk(1);
    nclk(300);
    chk(txd === 1'b1 && tx_idle === 1'b1, "R6 overflow write dropped", int'(txd), 1);

    // R7: single holding slot
    fifo_mode = 1'b0; divisor = 16'd1000;
    for (int i = 0; i < 3; i++) begin
      wr_en = 1'b1; wr_data = 8'(8'h11 * (i + 1));
      nclk(1);
    end
    wr_en = 1'b0;
    nclk(1);
    chk(tx_ready === 1'b0, "R7 ready low with one held", int'(tx_ready), 0);
    divisor = 16'd1;
    rx_frame(3, 0, 1, got, okf, fc);
    chk(got == 8'h11 && okf == 1, "R7 first", got, 8'h11);
    rx_frame(3, 0, 1, got, okf, fc);
    chk(got == 8'h22 && okf == 1, "R7 second", got, 8'h22);
    while (tx_idle !== 1'b1) nclk(1);
    nclk(300);
    chk(txd === 1'b1 && tx_idle === 1'b1, "R7 third write dropped", int'(txd), 1);
    chk(tx_ready === 1'b1, "R7 R10 ready when empty", int'(tx_ready), 1);

    done = 1'b1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule